// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Read Copy

This block counts time of day and calendar date in packed BCD: hundredths of a second, seconds, minutes, hours, day of the week, day of the month, month and two-digit year. It is clocked by the system clock and advances once for every pulse of a 100 Hz enable input. A second enable input at 1024 Hz feeds a square-wave flop whose output and output-enable are brought out separately, so that a pad cell elsewhere can provide the tri-state.

The counting happens in an internal copy that never pauses. Software sees a second, user-visible copy through a byte-wide register port. A transfer-enable control bit lets software freeze that copy, read or write a consistent snapshot, and then release it. Because the internal counters keep running, no time is lost. A host write to a time field loads both copies at once, so new time that is written during a freeze is already counting when the freeze ends.

The hour byte holds either a 24-hour value or a 12-hour value with a PM flag. Date roll-over knows the length of each month, including February in leap years up to 2099. The month byte also carries two active-low controls, one that stops the clock and one that enables the square wave.

Top module: `calclk_top`

## Requirements
- R1: After reset the registers read: hundredths, seconds, minutes, hours and year 0x00; day of week, date and month field 0x01; month byte 0xC1 (clock stopped, square wave off); control byte 0x80 (transfer enabled).
- R2: The register map is: address 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, 8 control. While the clock runs, every 100 Hz pulse adds one BCD count to hundredths. Going from 99 to 00 carries into seconds on the same edge.
- R3: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into the hour.
- R4: With hour bit 6 = 0 (24-hour), bits 5:4 hold tens of hours, so 09 is followed by 10 and 19 by 20. Hour 23 rolls to 00, advances day of week (07 wraps to 01) and advances the date.
- R5: With hour bit 6 = 1 (12-hour), bit 5 is PM (1 = PM) and bits 4:0 hold 01-12. 11 becomes 12 and flips PM. 12 becomes 01 and keeps PM. 11 PM becomes 12 AM and advances the date.
- R6: The date rolls to 01 and advances the month after 30 in April, June, September and November. In February it rolls after 29 when the year is divisible by four (year 00 counts as a leap year) and after 28 otherwise. In all other months it rolls after 31. Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R7: Control bit 7 is transfer enable. While it is 0, the readable time does not change but the internal time keeps counting. On the first pulse after it returns to 1, every readable field shows the fully advanced time.
- R8: A host write to a time field loads both the readable and the internal copy, whatever the transfer-enable setting. If a write and a 100 Hz pulse land on the same edge, the written value wins for that field and the other fields advance normally.
- R9: Month bit 7 = 1 stops the clock, so 100 Hz pulses are ignored. Month bit 7 = 0 lets the clock run.
- R10: Month bit 6 = 0 raises `sqw_oe` and makes `sqw` toggle on each 1024 Hz pulse. Month bit 6 = 1 drops `sqw_oe` and holds `sqw` low.
- R11: Bits without a function read 0 whatever was written: seconds, minutes and hours bit 7; day of week bits 7:3; date bits 7:6; month bit 5; control bits 6:0. Addresses 9 and above read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse, 100 times a second |
| tick_1024hz | input | 1 | One-cycle pulse, 1024 times a second |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sqw | output | 1 | Square-wave data |
| sqw_oe | output | 1 | Square-wave output enable for the pad |

## Verification
The two functions that can meet on one edge are the 100 Hz advance and a host write to a time field. The bench provokes this by raising `tick_100hz` and `reg_wr` in the same cycle. It does so once while hundredths reads 99 and the write targets seconds, and once with the write aimed at hundredths itself. It then reads back and expects the written byte in the addressed field, while the unaddressed fields show the normal advance, including the hundredths wrap and the untouched minutes. A second overlap is a write made while transfer is disabled; the bench judges it by reading that field during the freeze and again after counting resumes.

// File: rtl/calclk_pkg.sv
`timescale 1ns/1ps
package calclk_pkg;
   localparam int NF     = 8;
   localparam int F_HSEC = 0;
   localparam int F_SEC  = 1;
   localparam int F_MIN  = 2;
   localparam int F_HOUR = 3;
   localparam int F_WDAY = 4;
   localparam int F_DATE = 5;
   localparam int F_MON  = 6;
   localparam int F_YEAR = 7;
   localparam int A_CTL  = 8;

   typedef logic [NF-1:0][7:0] cal_vec_t;

   // Bits that hold state in each time field; the rest read as zero.
   function automatic logic [7:0] field_mask(input int idx);
      case (idx)
         F_SEC, F_MIN, F_HOUR: return 8'h7F;
         F_WDAY:               return 8'h07;
         F_DATE:               return 8'h3F;
         F_MON:                return 8'h1F;
         default:              return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      return v + 8'h01;
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      if (!yr[4]) return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
      return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
   endfunction

   function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // Returns {day_carry, next_hour_byte}.
   function automatic logic [8:0] hour_step(input logic [7:0] h);
      logic [7:0] lo;
      if (h[6]) begin
         lo = {3'b000, h[4:0]};
         if (lo == 8'h12) return {1'b0, h[7:5], 5'h01};
         if (lo == 8'h11) return {h[5], h[7:6], ~h[5], 5'h12};
         lo = bcd_inc(lo);
         return {1'b0, h[7:5], lo[4:0]};
      end
      lo = {2'b00, h[5:0]};
      if (lo >= 8'h23) return {1'b1, h[7:6], 6'h00};
      lo = bcd_inc(lo);
      return {1'b0, h[7:6], lo[5:0]};
   endfunction
endpackage

// File: rtl/calclk_counter.sv
`timescale 1ns/1ps
module calclk_counter
   import calclk_pkg::*;
#(
   parameter cal_vec_t RESET_TIME = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [NF-1:0] wr_sel,
   input  logic [7:0]    wr_val,
   output cal_vec_t      cur,
   output cal_vec_t      nxt
);
   cal_vec_t   stepped;
   logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
   logic [8:0] hstep;

   always_comb begin
      stepped = cur;
      c_sec   = 1'b0;
      c_min   = 1'b0;
      c_hour  = 1'b0;
      c_day   = 1'b0;
      c_mon   = 1'b0;
      c_year  = 1'b0;
      hstep   = hour_step(cur[F_HOUR]);
      if (adv) begin
         if (cur[F_HSEC] == 8'h99) begin
            stepped[F_HSEC] = 8'h00;
            c_sec = 1'b1;
         end else
            stepped[F_HSEC] = bcd_inc(cur[F_HSEC]);
      end
      if (c_sec) begin
         if (cur[F_SEC] >= 8'h59) begin
            stepped[F_SEC] = 8'h00;
            c_min = 1'b1;
         end else
            stepped[F_SEC] = bcd_inc(cur[F_SEC]);
      end
      if (c_min) begin
         if (cur[F_MIN] >= 8'h59) begin
            stepped[F_MIN] = 8'h00;
            c_hour = 1'b1;
         end else
            stepped[F_MIN] = bcd_inc(cur[F_MIN]);
      end
      if (c_hour) begin
         stepped[F_HOUR] = hstep[7:0];
         c_day = hstep[8];
      end
      if (c_day) begin
         stepped[F_WDAY] = (cur[F_WDAY] >= 8'h07) ? 8'h01 : bcd_inc(cur[F_WDAY]);
         if (cur[F_DATE] >= last_date(cur[F_MON], cur[F_YEAR])) begin
            stepped[F_DATE] = 8'h01;
            c_mon = 1'b1;
         end else
            stepped[F_DATE] = bcd_inc(cur[F_DATE]);
      end
      if (c_mon) begin
         if (cur[F_MON] >= 8'h12) begin
            stepped[F_MON] = 8'h01;
            c_year = 1'b1;
         end else
            stepped[F_MON] = bcd_inc(cur[F_MON]);
      end
      if (c_year)
         stepped[F_YEAR] = (cur[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cur[F_YEAR]);
   end

   for (genvar i = 0; i < NF; i++) begin : g_field
      assign nxt[i] = wr_sel[i] ? wr_val : stepped[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur <= RESET_TIME;
      else        cur <= nxt;
   end

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && wr_sel == '0) |=> $stable(cur));

   assert_hsec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wr_sel == '0 && cur[F_HSEC][3:0] != 4'h9)
      |=> cur[F_HSEC][3:0] == $past(cur[F_HSEC][3:0]) + 4'h1);

   assert_sec_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == '0 && cur[F_HSEC] != 8'h99) |=> $stable(cur[F_SEC]));
endmodule

// File: rtl/calclk_sqw.sv
`timescale 1ns/1ps
module calclk_sqw (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic off,
   output logic sqw,
   output logic sqw_oe
);
   always_ff @(posedge clk) begin
      if (!rst_n)           sqw <= 1'b0;
      else if (off)         sqw <= 1'b0;
      else if (run && tick) sqw <= ~sqw;
   end

   assign sqw_oe = ~off;

   assert_sqw_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> !sqw);
endmodule

// File: rtl/calclk_top.sv
`timescale 1ns/1ps
module calclk_top
   import calclk_pkg::*;
#(
   parameter int         ADDR_W    = 4,
   parameter logic [7:0] RST_WDAY  = 8'h01,
   parameter logic [7:0] RST_DATE  = 8'h01,
   parameter logic [7:0] RST_MONTH = 8'h01,
   parameter logic [7:0] RST_YEAR  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_100hz,
   input  logic              tick_1024hz,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              sqw,
   output logic              sqw_oe
);
   localparam cal_vec_t RESET_TIME =
      {RST_YEAR, RST_MONTH, RST_DATE, RST_WDAY, 8'h00, 8'h00, 8'h00, 8'h00};
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(A_CTL);

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("calclk_top: ADDR_W must be at least 4");
   end
   if (RST_WDAY < 8'h01 || RST_WDAY > 8'h07) begin : g_bad_wday
      $error("calclk_top: RST_WDAY out of range");
   end
   if (RST_MONTH < 8'h01 || RST_MONTH > 8'h12) begin : g_bad_month
      $error("calclk_top: RST_MONTH out of range");
   end

   logic          xfer_en, clk_off, wave_off, adv;
   logic [NF-1:0] wr_sel, load;
   logic [7:0]    wr_val;
   cal_vec_t      int_time, int_next, usr_time, usr_next;

   assign adv = tick_100hz & ~clk_off;

   for (genvar i = 0; i < NF; i++) begin : g_dec
      assign wr_sel[i]   = reg_wr && (reg_addr == ADDR_W'(i));
      assign load[i]     = wr_sel[i] || (adv && xfer_en);
      assign usr_next[i] = load[i] ? int_next[i] : usr_time[i];
   end

   always_comb begin
      wr_val = reg_wdata;
      for (int i = 0; i < NF; i++)
         if (reg_addr == ADDR_W'(i)) wr_val = reg_wdata & field_mask(i);
   end

   calclk_counter #(.RESET_TIME(RESET_TIME)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .wr_sel (wr_sel),
      .wr_val (wr_val),
      .cur    (int_time),
      .nxt    (int_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         usr_time <= RESET_TIME;
         xfer_en  <= 1'b1;
         clk_off  <= 1'b1;
         wave_off <= 1'b1;
      end else begin
         usr_time <= usr_next;
         if (reg_wr && reg_addr == CTL_ADDR) xfer_en <= reg_wdata[7];
         if (wr_sel[F_MON]) begin
            clk_off  <= reg_wdata[7];
            wave_off <= reg_wdata[6];
         end
      end
   end

   always_comb begin
      reg_rdata = 8'h00;
      if (reg_addr == CTL_ADDR)
         reg_rdata = {xfer_en, 7'b0};
      else if (reg_addr == ADDR_W'(F_MON))
         reg_rdata = {clk_off, wave_off, usr_time[F_MON][5:0]};
      else
         for (int i = 0; i < NF; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = usr_time[i];
   end

   calclk_sqw u_sqw (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1024hz),
      .run    (~clk_off),
      .off    (wave_off),
      .sqw    (sqw),
      .sqw_oe (sqw_oe)
   );

   assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_en && !reg_wr) |=> $stable(usr_time));

   assert_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && adv && !reg_wr) |=> (usr_time == int_time));

   assert_write_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[F_MIN] |=> (usr_time[F_MIN] == int_time[F_MIN]));
endmodule

// File: tb/calclk_top_test.sv
`timescale 1ns/1ps
module calclk_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_100hz = 1'b0;
   logic       tick_1024hz = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sqw, sqw_oe;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;

   calclk_top uut (
      .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_1024hz(tick_1024hz),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sqw(sqw), .sqw_oe(sqw_oe)
   );

   // {preset hs,s,m,h,wd,d,mon,yr ; ticks ; expected hs,s,m,h,wd,d,mon,yr}
   localparam int NV = 16;
   localparam logic [135:0] VEC [NV] = '{
      {64'h00_00_00_00_01_01_41_00, 8'd3,  64'h03_00_00_00_01_01_41_00},
      {64'h98_00_00_00_01_01_41_00, 8'd2,  64'h00_01_00_00_01_01_41_00},
      {64'h99_59_59_23_07_31_52_99, 8'd1,  64'h00_00_00_00_01_01_41_00},
      {64'h99_59_59_23_03_28_42_23, 8'd1,  64'h00_00_00_00_04_01_43_23},
      {64'h99_59_59_23_03_28_42_24, 8'd1,  64'h00_00_00_00_04_29_42_24},
      {64'h99_59_59_23_02_29_42_00, 8'd1,  64'h00_00_00_00_03_01_43_00},
      {64'h99_59_59_23_05_30_44_10, 8'd1,  64'h00_00_00_00_06_01_45_10},
      {64'h99_59_59_23_06_31_41_10, 8'd1,  64'h00_00_00_00_07_01_42_10},
      {64'h99_59_59_51_01_15_46_30, 8'd1,  64'h00_00_00_72_01_15_46_30},
      {64'h99_59_59_71_01_15_46_30, 8'd1,  64'h00_00_00_52_02_16_46_30},
      {64'h99_59_59_72_01_15_46_30, 8'd1,  64'h00_00_00_61_01_15_46_30},
      {64'h99_59_59_09_01_15_46_30, 8'd1,  64'h00_00_00_10_01_15_46_30},
      {64'h99_59_59_19_01_15_46_30, 8'd1,  64'h00_00_00_20_01_15_46_30},
      {64'h99_59_58_05_01_15_46_30, 8'd1,  64'h00_00_59_05_01_15_46_30},
      {64'h99_58_12_05_01_15_46_30, 8'd1,  64'h00_59_12_05_01_15_46_30},
      {64'h55_00_00_00_01_01_41_00, 8'd50, 64'h05_01_00_00_01_01_41_00}
   };
   localparam string VTAG [NV] = '{"R2", "R2", "R6", "R6", "R6", "R6", "R6", "R6",
                                   "R5", "R5", "R5", "R4", "R4", "R3", "R3", "R2"};

   task automatic chk(input string tag, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_100hz = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0;
   endtask

   task automatic collide(input int a, input logic [7:0] d);
      @(negedge clk);
      tick_100hz = 1'b1; reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic pulse_1024();
      @(negedge clk);
      tick_1024hz = 1'b1;
      @(negedge clk);
      tick_1024hz = 1'b0;
      #1;
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] rst_exp [9] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'hC1, 8'h00, 8'h80};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 9; a++) begin
         rd(a, d);
         chk("R1", $sformatf("reset addr %0d", a), d, rst_exp[a]);
      end
      chk("R10", "sqw_oe after reset", {7'b0, sqw_oe}, 8'h00);

      // R9: clock stopped after reset, pulses ignored
      repeat (5) tick();
      rd(0, d); chk("R9", "hsec while stopped", d, 8'h00);
      wr(6, 8'h41);
      repeat (3) tick();
      rd(0, d); chk("R9", "hsec after start", d, 8'h03);

      // Table of presets and expected results
      for (int v = 0; v < NV; v++) begin
         for (int f = 0; f < 8; f++) wr(f, VEC[v][135 - 8*f -: 8]);
         for (int k = 0; k < int'(VEC[v][71:64]); k++) tick();
         for (int f = 0; f < 8; f++) begin
            rd(f, d);
            chk(VTAG[v], $sformatf("vector %0d field %0d", v, f), d, VEC[v][63 - 8*f -: 8]);
         end
      end

      // R11: unused bits and unmapped addresses
      wr(1, 8'hFF); rd(1, d); chk("R11", "seconds bit7", d, 8'h7F);
      wr(4, 8'hFF); rd(4, d); chk("R11", "weekday upper bits", d, 8'h07);
      wr(5, 8'hFF); rd(5, d); chk("R11", "date upper bits", d, 8'h3F);
      wr(6, 8'hFF); rd(6, d); chk("R11", "month bit5", d, 8'hDF);
      wr(9, 8'hFF); rd(9, d); chk("R11", "unmapped addr", d, 8'h00);
      wr(8, 8'hFF); rd(8, d); chk("R11", "control low bits", d, 8'h80);
      wr(6, 8'h41);

      // R7: freeze while internal time keeps counting
      wr(0, 8'h98); wr(1, 8'h00); wr(2, 8'h00);
      wr(8, 8'h00);
      repeat (5) tick();
      rd(0, d); chk("R7", "frozen hsec", d, 8'h98);
      rd(1, d); chk("R7", "frozen sec", d, 8'h00);
      wr(8, 8'h80);
      tick();
      rd(0, d); chk("R7", "resumed hsec", d, 8'h04);
      rd(1, d); chk("R7", "resumed sec", d, 8'h01);

      // R8: write during freeze reaches both copies
      wr(8, 8'h00);
      wr(2, 8'h30);
      rd(2, d); chk("R8", "min written while frozen", d, 8'h30);
      tick();
      wr(8, 8'h80);
      tick();
      rd(2, d); chk("R8", "min after resume", d, 8'h30);
      rd(0, d); chk("R8", "hsec after resume", d, 8'h06);

      // R8: write and pulse on one edge
      wr(0, 8'h99); wr(1, 8'h10); wr(2, 8'h20);
      collide(1, 8'h45);
      rd(1, d); chk("R8", "sec write wins", d, 8'h45);
      rd(0, d); chk("R8", "hsec wraps", d, 8'h00);
      rd(2, d); chk("R8", "min untouched", d, 8'h20);
      collide(0, 8'h50);
      rd(0, d); chk("R8", "hsec write wins", d, 8'h50);

      // R10: square wave
      wr(6, 8'h01);
      #1;
      chk("R10", "sqw_oe on", {7'b0, sqw_oe}, 8'h01);
      chk("R10", "sqw start", {7'b0, sqw}, 8'h00);
      pulse_1024();
      chk("R10", "sqw first toggle", {7'b0, sqw}, 8'h01);
      pulse_1024();
      chk("R10", "sqw second toggle", {7'b0, sqw}, 8'h00);
      pulse_1024();
      wr(6, 8'h41);
      rd(6, d);
      chk("R10", "sqw_oe off", {7'b0, sqw_oe}, 8'h00);
      chk("R10", "sqw held low", {7'b0, sqw}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule